// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Matcher

This block is the slave side of an I2C-compatible two-wire bus. It watches the clock and data lines on the system clock. After every Start, including a repeated Start, it shifts in the first byte, most significant bit first. It compares the upper seven bits of that byte against two addresses:

- a programmable own address, but only when its enable is set;
- the general-call address 0x00, but only when general-call matching is enabled.

On a hit, the block acknowledges the byte. It latches the direction bit and raises a match flag and a new-match flag. It then moves data bytes in the requested direction.

Address matching depends on nothing except the bus lines and the configuration. A device that has just lost arbitration as a master can therefore still be addressed by the winning master.

Between bytes the block stretches the clock. It holds SCL low after each received byte until software reads the data register. It does the same whenever the transmit buffer is empty, until software writes the data register. Both lines are driven open-drain: the block only ever pulls them low.

Top module: `twi_slave_matcher`

## Requirements
- R1: A falling SDA while SCL is high is a Start. The next eight SCL rising edges capture a byte, MSB first. Bits 7..1 form the address and bit 0 is the direction (1 = master reads, so the slave transmits). When `ownAddrEn` is 1, the address is compared with `ownAddr`.
- R2: Address 0x00 is the general call. It produces a match only while `genCallEn` is 1.
- R3: While `ownAddrEn` is 0, `ownAddr` never produces a match.
- R4: On a match, the block pulls SDA low through the ninth SCL pulse. It also sets `matchFlag` and `newMatchFlag`, and `irq` goes high.
- R5: `xmitFlag` takes the captured direction bit. For a matched read, `bufEmpty` is set.
- R6: On a mismatch, the block does not acknowledge. It drives neither line until the next Start, so later bytes are not acknowledged and set no flag.
- R7: In slave receive, each 8-bit byte is captured MSB first and presented on `rdData`. After the eighth bit, SCL is held low until `swRdStrobe`; the byte is then acknowledged.
- R8: In slave transmit, SCL is held low while `bufEmpty` is 1. A `swWrStrobe` loads `swWrData` and clears `bufEmpty`. The byte is shifted out MSB first, and SDA only changes while SCL is low. An acknowledged byte sets `bufEmpty` again.
- R9: In slave transmit, a NACK from the master ends the transfer. SDA is released, `bufEmpty` stays 0, and SCL is not held until the next Start or Stop.
- R10: `newMatchClr` clears `newMatchFlag`. A Stop clears `matchFlag`.
- R11: A repeated Start restarts address capture, even after a mismatch.
- R12: After reset, both line drives are released and all flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sclDrvLow | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaDrvLow | output | 1 | 1 pulls SDA low |
| ownAddr | input | ADDR_W | Programmable own address |
| ownAddrEn | input | 1 | Enables own-address compare |
| genCallEn | input | 1 | Enables general-call compare |
| swWrData | input | ADDR_W+1 | Byte written to the data register |
| swWrStrobe | input | 1 | Data register write |
| swRdStrobe | input | 1 | Data register read |
| newMatchClr | input | 1 | Clears the new-match flag |
| rdData | output | ADDR_W+1 | Last received byte |
| matchFlag | output | 1 | Addressed in the current transfer |
| newMatchFlag | output | 1 | Address match not yet acknowledged by software |
| xmitFlag | output | 1 | Matched direction is slave transmit |
| bufEmpty | output | 1 | Transmit buffer needs a byte |
| irq | output | 1 | Service request |

## Verification
The hardest states to reach are the stretch intervals. The block holds SCL while the bus master is trying to raise it. The bench models the bus as a wired-AND of master and slave drives, and its master waits for the real line to go high before it continues. A separate software thread runs concurrently with the master. It confirms that the line stays low for tens of cycles and only then touches the data register.

The NACK that ends a transmit needs the same setup. It is reached by letting the master refuse a second byte. The bench then clocks a further byte and checks that only ones come back.

// File: rtl/twim_pkg.sv
package twim_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_RX,
    S_RX_WAIT,
    S_RX_ACK,
    S_TX_WAIT,
    S_TX_LOAD,
    S_TX,
    S_TX_ACK
  } twimState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic latchRx;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

endpackage

// File: rtl/twim_dpath.sv
module twim_dpath
  import twim_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              ownAddrEn,
  input  logic              genCallEn,
  input  logic [ADDR_W:0]   swWrData,
  input  logic              swWrStrobe,
  input  dpStrobe_t         strobe,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic              addrHit,
  output logic              rwBit,
  output logic              txBit,
  output logic [ADDR_W:0]   rdData
);
  localparam int BYTE_W = ADDR_W + 1;

  logic              sclPrev, sdaPrev;
  logic [BYTE_W-1:0] shiftReg, txShift, txData;
  logic              ownHit, gcHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
      shiftReg <= '0;
      txShift  <= '1;
      txData   <= '1;
      rdData   <= '0;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
      if (strobe.shiftIn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};
      if (strobe.latchRx) rdData <= shiftReg;
      if (swWrStrobe)     txData <= swWrData;
      if (strobe.loadTx)       txShift <= txData;
      else if (strobe.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  assign sclRise = sclIn & ~sclPrev;
  assign sclFall = ~sclIn & sclPrev;
  assign startEv = sclIn & sclPrev & sdaPrev & ~sdaIn;
  assign stopEv  = sclIn & sclPrev & ~sdaPrev & sdaIn;

  assign ownHit  = ownAddrEn && (shiftReg[BYTE_W-1:1] == ownAddr);
  assign gcHit   = genCallEn && (shiftReg[BYTE_W-1:1] == '0);
  assign addrHit = ownHit | gcHit;
  assign rwBit   = shiftReg[0];
  assign txBit   = txShift[BYTE_W-1];

  // R1: captured bit lands in the LSB, older bits move toward the MSB
  a_r1_shift_msb_first: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftIn |=> (shiftReg[0] == $past(sdaIn)));

  // R2: an all-zero address hits only with general call enabled or an own address of zero
  a_r2_gc_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && shiftReg[BYTE_W-1:1] == '0) |-> (genCallEn || (ownAddrEn && ownAddr == '0)));

endmodule

// File: rtl/twim_ctrl.sv
module twim_ctrl
  import twim_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startEv,
  input  logic      stopEv,
  input  logic      addrHit,
  input  logic      rwBit,
  input  logic      txBit,
  input  logic      swWrStrobe,
  input  logic      swRdStrobe,
  input  logic      newMatchClr,
  output dpStrobe_t strobe,
  output logic      sclDrvLow,
  output logic      sdaDrvLow,
  output logic      matchFlag,
  output logic      newMatchFlag,
  output logic      xmitFlag,
  output logic      bufEmpty,
  output logic      irq
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  twimState_e       state;
  logic [CNT_W-1:0] bitCnt;
  logic             rxFull, ackSeen;

  always_comb begin
    strobe    = '0;
    sdaDrvLow = 1'b0;
    sclDrvLow = 1'b0;
    case (state)
      S_ADDR:     strobe.shiftIn = sclRise;
      S_ADDR_ACK: sdaDrvLow = 1'b1;
      S_RX: begin
        strobe.shiftIn = sclRise;
        strobe.latchRx = sclFall && (bitCnt == CNT_FULL);
      end
      S_RX_WAIT: begin
        sdaDrvLow = 1'b1;
        sclDrvLow = 1'b1;
      end
      S_RX_ACK:  sdaDrvLow = 1'b1;
      S_TX_WAIT: begin
        sclDrvLow     = 1'b1;
        strobe.loadTx = !bufEmpty;
      end
      S_TX_LOAD: begin
        sclDrvLow = 1'b1;
        sdaDrvLow = !txBit;
      end
      S_TX: begin
        sdaDrvLow      = !txBit;
        strobe.shiftTx = sclFall;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      bitCnt       <= '0;
      matchFlag    <= 1'b0;
      newMatchFlag <= 1'b0;
      xmitFlag     <= 1'b0;
      bufEmpty     <= 1'b0;
      rxFull       <= 1'b0;
      ackSeen      <= 1'b0;
    end else begin
      if (newMatchClr) newMatchFlag <= 1'b0;
      if (swRdStrobe)  rxFull <= 1'b0;
      if (swWrStrobe)  bufEmpty <= 1'b0;
      if (startEv) begin
        state     <= S_ADDR;
        bitCnt    <= '0;
        matchFlag <= 1'b0;
        xmitFlag  <= 1'b0;
        bufEmpty  <= 1'b0;
        rxFull    <= 1'b0;
      end else if (stopEv) begin
        state     <= S_IDLE;
        matchFlag <= 1'b0;
        bufEmpty  <= 1'b0;
        rxFull    <= 1'b0;
      end else begin
        case (state)
          S_ADDR:
            if (sclRise) bitCnt <= bitCnt + 1'b1;
            else if (sclFall && bitCnt == CNT_FULL) begin
              if (addrHit) begin
                state        <= S_ADDR_ACK;
                matchFlag    <= 1'b1;
                newMatchFlag <= 1'b1;
                xmitFlag     <= rwBit;
                bufEmpty     <= rwBit;
              end else begin
                state <= S_IDLE;
              end
            end
          S_ADDR_ACK:
            if (sclFall) begin
              bitCnt <= '0;
              state  <= xmitFlag ? S_TX_WAIT : S_RX;
            end
          S_RX:
            if (sclRise) bitCnt <= bitCnt + 1'b1;
            else if (sclFall && bitCnt == CNT_FULL) begin
              rxFull <= 1'b1;
              state  <= S_RX_WAIT;
            end
          S_RX_WAIT: if (!rxFull) state <= S_RX_ACK;
          S_RX_ACK:
            if (sclFall) begin
              bitCnt <= '0;
              state  <= S_RX;
            end
          S_TX_WAIT: if (!bufEmpty) state <= S_TX_LOAD;
          S_TX_LOAD: begin
            bitCnt <= '0;
            state  <= S_TX;
          end
          S_TX:
            if (sclFall) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == CNT_LAST) state <= S_TX_ACK;
            end
          S_TX_ACK:
            if (sclRise) ackSeen <= !sdaIn;
            else if (sclFall) begin
              if (ackSeen) begin
                bufEmpty <= 1'b1;
                state    <= S_TX_WAIT;
              end else begin
                state <= S_IDLE;
              end
            end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign irq = newMatchFlag | rxFull | bufEmpty;

  // R8: the slave's SDA drive only moves while SCL is low
  a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvLow) |-> !sclIn);

  // R7: a received byte waiting for software keeps SCL held
  a_r7_hold_while_full: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> sclDrvLow);

  // R5: the empty-buffer flag only exists in transmit direction
  a_r5_empty_only_tx: assert property (@(posedge clk) disable iff (!rstN)
    bufEmpty |-> xmitFlag);

  // R4: a hit at the end of the address byte acknowledges and flags it
  a_r4_match_acks: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && sclFall && bitCnt == CNT_FULL && addrHit && !startEv && !stopEv)
    |=> (sdaDrvLow && newMatchFlag && matchFlag));

  // R9: a master NACK leaves SDA released and the buffer not requested
  a_r9_nack_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TX_ACK && sclFall && !ackSeen && !startEv && !stopEv)
    |=> (!sdaDrvLow && !bufEmpty && !sclDrvLow));

endmodule

// File: rtl/twi_slave_matcher.sv
module twi_slave_matcher
  import twim_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDrvLow,
  output logic              sdaDrvLow,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              ownAddrEn,
  input  logic              genCallEn,
  input  logic [ADDR_W:0]   swWrData,
  input  logic              swWrStrobe,
  input  logic              swRdStrobe,
  input  logic              newMatchClr,
  output logic [ADDR_W:0]   rdData,
  output logic              matchFlag,
  output logic              newMatchFlag,
  output logic              xmitFlag,
  output logic              bufEmpty,
  output logic              irq
);
  dpStrobe_t strobe;
  logic sclRise, sclFall, startEv, stopEv, addrHit, rwBit, txBit;

  twim_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .ownAddrEn(ownAddrEn), .genCallEn(genCallEn),
    .swWrData(swWrData), .swWrStrobe(swWrStrobe), .strobe(strobe),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .addrHit(addrHit), .rwBit(rwBit), .txBit(txBit), .rdData(rdData)
  );

  twim_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .addrHit(addrHit), .rwBit(rwBit), .txBit(txBit),
    .swWrStrobe(swWrStrobe), .swRdStrobe(swRdStrobe), .newMatchClr(newMatchClr),
    .strobe(strobe), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .matchFlag(matchFlag), .newMatchFlag(newMatchFlag), .xmitFlag(xmitFlag),
    .bufEmpty(bufEmpty), .irq(irq)
  );

endmodule

// File: tb/twi_slave_matcher_tb.sv
module twi_slave_matcher_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclDrvLow, sdaDrvLow, sclLine, sdaLine;
  logic [6:0] ownAddr = 7'h00;
  logic ownAddrEn = 1'b0, genCallEn = 1'b0;
  logic [7:0] swWrData = 8'h00;
  logic swWrStrobe = 1'b0, swRdStrobe = 1'b0, newMatchClr = 1'b0;
  logic [7:0] rdData;
  logic matchFlag, newMatchFlag, xmitFlag, bufEmpty, irq;

  assign sclLine = mScl & ~sclDrvLow;
  assign sdaLine = mSda & ~sdaDrvLow;

  twi_slave_matcher u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .ownAddr(ownAddr), .ownAddrEn(ownAddrEn), .genCallEn(genCallEn),
    .swWrData(swWrData), .swWrStrobe(swWrStrobe), .swRdStrobe(swRdStrobe),
    .newMatchClr(newMatchClr), .rdData(rdData), .matchFlag(matchFlag),
    .newMatchFlag(newMatchFlag), .xmitFlag(xmitFlag), .bufEmpty(bufEmpty), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  // {ownAddrEn, genCallEn, ownAddr, addressByte, expectAck, expectXmit}
  localparam int NVEC = 10;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 7'h42, 8'h84, 1'b1, 1'b0},
    {1'b1, 1'b0, 7'h42, 8'h85, 1'b1, 1'b1},
    {1'b1, 1'b0, 7'h42, 8'h86, 1'b0, 1'b0},
    {1'b0, 1'b0, 7'h42, 8'h84, 1'b0, 1'b0},
    {1'b0, 1'b1, 7'h42, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 7'h42, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b1, 7'h42, 8'h84, 1'b1, 1'b0},
    {1'b0, 1'b1, 7'h42, 8'h84, 1'b0, 1'b0},
    {1'b1, 1'b0, 7'h7F, 8'hFF, 1'b1, 1'b1},
    {1'b1, 1'b0, 7'h01, 8'h02, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitSclHigh();
    while (!sclLine) cyc(1);
  endtask

  task automatic startCond();
    cyc(2); mSda = 1'b1;
    cyc(2); mScl = 1'b1;
    waitSclHigh();
    cyc(4); mSda = 1'b0;
    cyc(4); mScl = 1'b0;
    cyc(4);
  endtask

  task automatic stopCond();
    mSda = 1'b0;
    cyc(2); mScl = 1'b1;
    waitSclHigh();
    cyc(4); mSda = 1'b1;
    cyc(4);
  endtask

  task automatic clockBit(input logic b, output logic s);
    mSda = b;
    cyc(3); mScl = 1'b1;
    waitSclHigh();
    cyc(3); s = sdaLine;
    cyc(3); mScl = 1'b0;
    cyc(4);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(d[i], s);
    clockBit(1'b1, s);
    ack = !s;
  endtask

  task automatic recvByte(input logic masterAck, output logic [7:0] d);
    logic s;
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      d = {d[6:0], s};
    end
    clockBit(!masterAck, s);
  endtask

  task automatic pulseClr();
    newMatchClr = 1'b1; cyc(1); newMatchClr = 1'b0; cyc(1);
  endtask

  task automatic pulseRd();
    swRdStrobe = 1'b1; cyc(1); swRdStrobe = 1'b0; cyc(1);
  endtask

  task automatic swWrite(input logic [7:0] d);
    swWrData = d; swWrStrobe = 1'b1; cyc(1); swWrStrobe = 1'b0; cyc(1);
  endtask

  logic        ackB;
  logic [7:0]  dataB;
  logic [18:0] v;

  initial begin
    cyc(5);
    // R12: reset state
    chk("R12 sda drive", sdaDrvLow, 0);
    chk("R12 scl drive", sclDrvLow, 0);
    chk("R12 flags", {matchFlag, newMatchFlag, xmitFlag, bufEmpty, irq}, 0);
    rstN = 1'b1;
    cyc(3);
    chk("R12 idle after reset", {sdaDrvLow, sclDrvLow, irq}, 0);

    // address table: R1 R2 R3 R4 R5 R10
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      ownAddrEn = v[18]; genCallEn = v[17]; ownAddr = v[16:10];
      startCond();
      sendByte(v[9:2], ackB);
      chk($sformatf("R1 R2 R3 R4 ack vec%0d", i), ackB, v[1]);
      chk($sformatf("R4 newMatch vec%0d", i), newMatchFlag, v[1]);
      chk($sformatf("R4 match vec%0d", i), matchFlag, v[1]);
      if (v[1]) begin
        chk($sformatf("R4 irq vec%0d", i), irq, 1);
        chk($sformatf("R5 xmit vec%0d", i), xmitFlag, v[0]);
        chk($sformatf("R5 bufEmpty vec%0d", i), bufEmpty, v[0]);
        if (v[0]) swWrite(8'hFF);
      end
      pulseClr();
      stopCond();
      chk($sformatf("R10 match cleared by stop vec%0d", i), matchFlag, 0);
    end

    // R6 and R11: mismatch ignored, repeated start recaptures
    ownAddrEn = 1'b1; genCallEn = 1'b0; ownAddr = 7'h42;
    startCond();
    sendByte(8'h86, ackB);
    chk("R6 mismatch nack", ackB, 0);
    sendByte(8'h84, ackB);
    chk("R6 later byte ignored", ackB, 0);
    chk("R6 no newMatch", newMatchFlag, 0);
    startCond();
    sendByte(8'h84, ackB);
    chk("R11 repeated start match", ackB, 1);
    chk("R11 newMatch", newMatchFlag, 1);
    pulseClr();
    chk("R10 newMatch cleared", newMatchFlag, 0);

    // R7: slave receive with stretch
    fork
      begin
        sendByte(8'hC3, ackB);
      end
      begin
        while (!irq) cyc(1);
        cyc(30);
        chk("R7 scl held until read", sclLine, 0);
        chk("R7 rdData", rdData, 8'hC3);
        pulseRd();
      end
    join
    chk("R7 data ack", ackB, 1);
    fork
      begin
        sendByte(8'h5A, ackB);
      end
      begin
        while (!irq) cyc(1);
        chk("R7 rdData second", rdData, 8'h5A);
        pulseRd();
      end
    join
    chk("R7 second ack", ackB, 1);
    stopCond();
    chk("R10 match cleared after rx", matchFlag, 0);

    // R8 and R9: slave transmit
    startCond();
    sendByte(8'h85, ackB);
    chk("R5 read match ack", ackB, 1);
    chk("R5 read bufEmpty", bufEmpty, 1);
    pulseClr();
    fork
      begin
        recvByte(1'b1, dataB);
      end
      begin
        cyc(40);
        chk("R8 scl held while empty", sclLine, 0);
        chk("R8 bufEmpty during hold", bufEmpty, 1);
        swWrite(8'hA5);
      end
    join
    chk("R8 tx byte", dataB, 8'hA5);
    chk("R8 bufEmpty after ack", bufEmpty, 1);
    swWrite(8'h3C);
    recvByte(1'b0, dataB);
    chk("R8 tx second byte", dataB, 8'h3C);
    chk("R9 bufEmpty after nack", bufEmpty, 0);
    chk("R9 sda released", sdaDrvLow, 0);
    chk("R9 irq low", irq, 0);
    recvByte(1'b0, dataB);
    chk("R9 no drive after nack", dataB, 8'hFF);
    stopCond();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule